// File: doc/BRIEF.md
# Shared-Source Interrupt Request Controller

This block collects six interrupt requests for a small 8-bit microcontroller core and presents one prioritized pending vector. Three request slots come from port lines, two from counter/timers and one from a low-voltage detector. Two of the port-line slots are shared with on-chip events. One slot is taken over by the UART receive event when the receiver is enabled. The other slot can be driven by the UART transmit event, the baud-rate-generator event or the stop-mode wake logic, depending on configuration bits that the surrounding chip supplies.

Each slot latches a rising edge of its currently selected event into a request register. A mask register gates the latched requests, with one enable bit per slot and a global enable bit. A three-bit ordering code in the priority register ranks three slot groups against each other, and within a group the lower slot index wins. The CPU reads and writes the three registers through a simple address/data port, sees `irq_pending` and `irq_vector`, and pulses `irq_ack` to retire the request it is being shown.

Top module: `irq_share_ctrl`

## Requirements
- R1: After reset the request register reads 00h, mask bit 7 (global enable) reads 0 and `irq_pending` is low.
- R2: Slot 0 latches a rising edge of `port_line_b` while `rx_enable` is 0, and a rising edge of `ev_uart_rx` while `rx_enable` is 1; the deselected event never sets slot 0.
- R3: When `uart_ctl` bit 7 is 1, slot 1 is set only by a rising edge of `ev_uart_tx`. When bit 7 is 0 and bit 5 is 1, slot 1 is set only by `ev_baud`.
- R4: When `uart_ctl` bits 7 and 5 are both 0, slot 1 is set by `ev_wake` if `port_mode` bit 1 or `wake_ctl` bit 4 is 1, and otherwise by `port_line_c`. Deselected events never set slot 1.
- R5: Slot 2 is set by `port_line_a`, slot 3 by `ev_timer[0]`, slot 4 by `ev_timer[1]` and slot 5 by `ev_lowvolt`.
- R6: Mask bits 5:0 (address FBh) enable slots 0 to 5 individually. A masked request stays latched but is never presented.
- R7: While mask bit 7 is 0, `irq_pending` is low, and latched requests are kept.
- R8: Priority register bits 2:0 (address F9h) order the groups G0={0,1}, G1={2,3} and G2={4,5} as follows: code 0 gives G0,G1,G2; code 1 gives G0,G2,G1; code 2 gives G1,G0,G2; code 3 gives G1,G2,G0; code 4 gives G2,G0,G1; code 5 gives G2,G1,G0; codes 6 and 7 act as code 0. The first group in the order that has an enabled pending slot supplies `irq_vector`.
- R9: Within a group, the lower slot index wins.
- R10: An `irq_ack` pulse while `irq_pending` is high clears the request bit of the presented vector at the next clock.
- R11: Register reads work as follows. FAh reads {00, request[5:0]} and a write loads request[5:0]. FBh reads {global, 0, mask[5:0]}. F9h reads {00000, order[2:0]}. Any other address reads 00h.
- R12: A request edge in the same cycle as an acknowledge or a request-register write leaves that bit set.
- R13: Requests are edge-triggered. An event held high sets its bit only once, even after the bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| port_line_a | input | 1 | Port line feeding slot 2 |
| port_line_b | input | 1 | Port line shared with UART receive on slot 0 |
| port_line_c | input | 1 | Port line shared on slot 1 |
| ev_uart_rx | input | 1 | UART receive event |
| ev_uart_tx | input | 1 | UART transmit event |
| ev_baud | input | 1 | Baud-rate-generator event |
| ev_wake | input | 1 | Stop-mode wake logic output |
| ev_timer | input | 2 | Counter/timer events |
| ev_lowvolt | input | 1 | Low-voltage detect event |
| rx_enable | input | 1 | UART receiver enabled |
| uart_ctl | input | 8 | UART control (bits 7 and 5 used) |
| port_mode | input | 8 | Port mode (bit 1 used) |
| wake_ctl | input | 8 | Wake control (bit 4 used) |
| irq_ack | input | 1 | CPU acknowledge of presented request |
| irq_pending | output | 1 | An enabled request is pending |
| irq_vector | output | 3 | Slot index of presented request |

## Verification
The bench builds the block with its default parameters: 8-bit addresses with the registers at F9h, FAh and FBh, and the select bits at UART-control positions 7 and 5, port-mode bit 1 and wake-control bit 4. These values make every select combination of both shared slots reachable through the control-byte inputs. They also let the bench apply all eight ordering codes against six slots, so every group ranking and both in-group tie-breaks are exercised. A long phase of random events, acknowledges and register writes, with the configuration changing from time to time, checks the same-cycle collisions between set, acknowledge and write against the reference model.

// File: rtl/irq_share_pkg.sv
package irq_share_pkg;

    localparam int SLOTS      = 6;
    localparam int GROUP_SIZE = 2;
    localparam int GROUPS     = SLOTS / GROUP_SIZE;
    localparam int IDX_W      = $clog2(SLOTS);
    localparam int ORD_W      = 3;

    // slot numbering
    localparam int SLOT_SHARED_RX   = 0;
    localparam int SLOT_SHARED_MULT = 1;
    localparam int SLOT_LINE_A      = 2;
    localparam int SLOT_TIMER0      = 3;
    localparam int SLOT_TIMER1      = 4;
    localparam int SLOT_LOWVOLT     = 5;

    typedef logic [SLOTS-1:0] slot_vec_t;
    typedef logic [IDX_W-1:0] slot_idx_t;
    typedef logic [ORD_W-1:0] order_code_t;

    typedef struct packed {
        logic       line_a;
        logic       line_b;
        logic       line_c;
        logic       uart_rx;
        logic       uart_tx;
        logic       baud;
        logic       wake;
        logic [1:0] timer;
        logic       lowvolt;
    } raw_ev_t;

    typedef struct packed {
        logic rx_en;
        logic tx_sel;
        logic baud_sel;
        logic wake_sel;
    } src_sel_t;

    // Group ranked at position pos (0 = highest) for a given order code.
    function automatic logic [1:0] group_at(input order_code_t code, input int unsigned pos);
        logic [5:0] ord;
        case (code)
            3'd1:    ord = {2'd1, 2'd2, 2'd0};
            3'd2:    ord = {2'd2, 2'd0, 2'd1};
            3'd3:    ord = {2'd0, 2'd2, 2'd1};
            3'd4:    ord = {2'd1, 2'd0, 2'd2};
            3'd5:    ord = {2'd0, 2'd1, 2'd2};
            default: ord = {2'd2, 2'd1, 2'd0};
        endcase
        return ord[pos*2 +: 2];
    endfunction

endpackage

// File: rtl/irq_src_route.sv
module irq_src_route
    import irq_share_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  raw_ev_t   ev,
    input  src_sel_t  sel,
    output slot_vec_t set_o
);

    raw_ev_t prev_q;
    raw_ev_t rise;

    // Reset captures the live levels so release produces no spurious edge.
    always_ff @(posedge clk) begin
        if (rst) prev_q <= ev;
        else     prev_q <= ev;
    end

    assign rise = ev & ~prev_q;

    always_comb begin
        set_o = '0;
        set_o[SLOT_SHARED_RX] = sel.rx_en ? rise.uart_rx : rise.line_b;
        if (sel.tx_sel)
            set_o[SLOT_SHARED_MULT] = rise.uart_tx;
        else if (sel.baud_sel)
            set_o[SLOT_SHARED_MULT] = rise.baud;
        else if (sel.wake_sel)
            set_o[SLOT_SHARED_MULT] = rise.wake;
        else
            set_o[SLOT_SHARED_MULT] = rise.line_c;
        set_o[SLOT_LINE_A]  = rise.line_a;
        set_o[SLOT_TIMER0]  = rise.timer[0];
        set_o[SLOT_TIMER1]  = rise.timer[1];
        set_o[SLOT_LOWVOLT] = rise.lowvolt;
    end

endmodule

// File: rtl/irq_req_regs.sv
module irq_req_regs
    import irq_share_pkg::*;
#(
    parameter int                  ADDR_W     = 8,
    parameter int                  DATA_W     = 8,
    parameter logic [ADDR_W-1:0]   PRIO_ADDR  = 'hF9,
    parameter logic [ADDR_W-1:0]   REQ_ADDR   = 'hFA,
    parameter logic [ADDR_W-1:0]   MASK_ADDR  = 'hFB,
    parameter int                  GLOBAL_BIT = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  slot_vec_t         set_i,
    input  slot_vec_t         ack_clr_i,
    output slot_vec_t         req_o,
    output slot_vec_t         mask_o,
    output logic              glob_o,
    output slot_vec_t         active_o,
    output order_code_t       order_o
);

    slot_vec_t   req_q, req_d, req_base, mask_q;
    logic        glob_q;
    order_code_t order_q;

    wire wr_req  = wr && (addr == REQ_ADDR);
    wire wr_mask = wr && (addr == MASK_ADDR);
    wire wr_prio = wr && (addr == PRIO_ADDR);

    always_comb begin
        req_base = wr_req ? wdata[SLOTS-1:0] : req_q;
        req_d    = (req_base & ~ack_clr_i) | set_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q   <= '0;
            mask_q  <= '0;
            glob_q  <= 1'b0;
            order_q <= '0;
        end else begin
            req_q <= req_d;
            if (wr_mask) begin
                mask_q <= wdata[SLOTS-1:0];
                glob_q <= wdata[GLOBAL_BIT];
            end
            if (wr_prio) order_q <= wdata[ORD_W-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == REQ_ADDR) begin
            rdata[SLOTS-1:0] = req_q;
        end else if (addr == MASK_ADDR) begin
            rdata[SLOTS-1:0]  = mask_q;
            rdata[GLOBAL_BIT] = glob_q;
        end else if (addr == PRIO_ADDR) begin
            rdata[ORD_W-1:0] = order_q;
        end
    end

    assign req_o    = req_q;
    assign mask_o   = mask_q;
    assign glob_o   = glob_q;
    assign order_o  = order_q;
    assign active_o = req_q & mask_q & {SLOTS{glob_q}};

    // R1: reset leaves no latched request and global enable off
    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(rst) |-> (req_q == '0 && !glob_q));

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_share_pkg::*;
(
    input  slot_vec_t   active_i,
    input  order_code_t order_i,
    output logic        pending_o,
    output slot_idx_t   vector_o
);

    logic [GROUPS-1:0] grp_any;
    slot_idx_t         grp_idx [GROUPS];

    for (genvar g = 0; g < GROUPS; g++) begin : g_group
        assign grp_any[g] = |active_i[g*GROUP_SIZE +: GROUP_SIZE];
        always_comb begin
            grp_idx[g] = slot_idx_t'(g*GROUP_SIZE);
            for (int k = GROUP_SIZE-1; k >= 0; k--) begin
                if (active_i[g*GROUP_SIZE + k]) grp_idx[g] = slot_idx_t'(g*GROUP_SIZE + k);
            end
        end
    end

    always_comb begin
        logic [1:0] g_sel;
        pending_o = 1'b0;
        vector_o  = '0;
        for (int pos = GROUPS-1; pos >= 0; pos--) begin
            g_sel = group_at(order_i, pos);
            if (grp_any[g_sel]) begin
                pending_o = 1'b1;
                vector_o  = grp_idx[g_sel];
            end
        end
    end

endmodule

// File: rtl/irq_share_ctrl.sv
module irq_share_ctrl
    import irq_share_pkg::*;
#(
    parameter int                ADDR_W       = 8,
    parameter int                DATA_W       = 8,
    parameter logic [ADDR_W-1:0] PRIO_ADDR    = 'hF9,
    parameter logic [ADDR_W-1:0] REQ_ADDR     = 'hFA,
    parameter logic [ADDR_W-1:0] MASK_ADDR    = 'hFB,
    parameter int                GLOBAL_BIT   = 7,
    parameter int                TX_SEL_BIT   = 7,
    parameter int                BAUD_SEL_BIT = 5,
    parameter int                ANALOG_BIT   = 1,
    parameter int                WAKE_EN_BIT  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              port_line_a,
    input  logic              port_line_b,
    input  logic              port_line_c,
    input  logic              ev_uart_rx,
    input  logic              ev_uart_tx,
    input  logic              ev_baud,
    input  logic              ev_wake,
    input  logic [1:0]        ev_timer,
    input  logic              ev_lowvolt,
    input  logic              rx_enable,
    input  logic [DATA_W-1:0] uart_ctl,
    input  logic [DATA_W-1:0] port_mode,
    input  logic [DATA_W-1:0] wake_ctl,
    input  logic              irq_ack,
    output logic              irq_pending,
    output logic [IDX_W-1:0]  irq_vector
);

    raw_ev_t     raw;
    src_sel_t    sel;
    slot_vec_t   set_v, ack_clr, req_q, mask_q, active;
    logic        glob;
    order_code_t order;

    assign raw = '{line_a: port_line_a, line_b: port_line_b, line_c: port_line_c,
                   uart_rx: ev_uart_rx, uart_tx: ev_uart_tx, baud: ev_baud,
                   wake: ev_wake, timer: ev_timer, lowvolt: ev_lowvolt};

    assign sel = '{rx_en:    rx_enable,
                   tx_sel:   uart_ctl[TX_SEL_BIT],
                   baud_sel: uart_ctl[BAUD_SEL_BIT],
                   wake_sel: port_mode[ANALOG_BIT] | wake_ctl[WAKE_EN_BIT]};

    irq_src_route u_route (
        .clk   (clk),
        .rst   (rst),
        .ev    (raw),
        .sel   (sel),
        .set_o (set_v)
    );

    assign ack_clr = (irq_ack && irq_pending) ? (slot_vec_t'(1) << irq_vector) : '0;

    irq_req_regs #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .PRIO_ADDR (PRIO_ADDR),
        .REQ_ADDR  (REQ_ADDR),
        .MASK_ADDR (MASK_ADDR),
        .GLOBAL_BIT(GLOBAL_BIT)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .addr      (reg_addr),
        .wr        (reg_wr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .set_i     (set_v),
        .ack_clr_i (ack_clr),
        .req_o     (req_q),
        .mask_o    (mask_q),
        .glob_o    (glob),
        .active_o  (active),
        .order_o   (order)
    );

    irq_arbiter u_arb (
        .active_i  (active),
        .order_i   (order),
        .pending_o (irq_pending),
        .vector_o  (irq_vector)
    );

    // R2: a new slot-0 request comes only from the event selected in the cycle before
    assert_slot0_source_R2: assert property (@(posedge clk) disable iff (rst)
        ($rose(req_q[SLOT_SHARED_RX]) && !$past(reg_wr && reg_addr == REQ_ADDR)) |->
        ($past(rx_enable) ? ($past(ev_uart_rx) && !$past(ev_uart_rx, 2))
                          : ($past(port_line_b) && !$past(port_line_b, 2))));

    // R6: the presented slot is latched and individually enabled
    assert_vec_enabled_R6: assert property (@(posedge clk) disable iff (rst)
        irq_pending |-> (req_q[irq_vector] && mask_q[irq_vector]));

    // R7: global disable hides every request
    assert_global_off_R7: assert property (@(posedge clk) disable iff (rst)
        !glob |-> !irq_pending);

    // R8: presented vector is a real slot
    assert_vec_range_R8: assert property (@(posedge clk) disable iff (rst)
        irq_pending |-> (int'(irq_vector) < SLOTS));

endmodule

// File: tb/sim_irq_share_ctrl.sv
`timescale 1ns/1ps
module sim_irq_share_ctrl;

    localparam logic [7:0] A_PRIO = 8'hF9;
    localparam logic [7:0] A_REQ  = 8'hFA;
    localparam logic [7:0] A_MASK = 8'hFB;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] reg_addr = 8'h00;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    // 0 line_a,1 line_b,2 line_c,3 rx,4 tx,5 baud,6 wake,7 t0,8 t1,9 lowvolt
    logic [9:0] evb = '0;
    logic       rx_enable = 1'b0;
    logic [7:0] uart_ctl = 8'h00, port_mode = 8'h00, wake_ctl = 8'h00;
    logic       irq_ack = 1'b0;
    logic       irq_pending;
    logic [2:0] irq_vector;

    int checks = 0, errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    irq_share_ctrl u0 (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .port_line_a(evb[0]), .port_line_b(evb[1]), .port_line_c(evb[2]),
        .ev_uart_rx(evb[3]), .ev_uart_tx(evb[4]), .ev_baud(evb[5]),
        .ev_wake(evb[6]), .ev_timer(evb[8:7]), .ev_lowvolt(evb[9]),
        .rx_enable(rx_enable), .uart_ctl(uart_ctl), .port_mode(port_mode),
        .wake_ctl(wake_ctl), .irq_ack(irq_ack),
        .irq_pending(irq_pending), .irq_vector(irq_vector)
    );

    // ---------------- reference model ----------------
    logic [5:0] m_req = '0, m_mask = '0;
    logic       m_glob = 1'b0;
    logic [2:0] m_ord = '0;
    logic [9:0] m_prev = '0;
    logic [9:0] e;
    logic [5:0] sv, nx;
    logic [3:0] pk;

    function automatic logic [3:0] ref_pick(logic [5:0] act, logic [2:0] oc);
        int code, n, t;
        int ord[3];
        code = (oc > 3'd5) ? 0 : int'(oc);
        ord[0] = code / 2;
        n = 1;
        for (int g = 0; g < 3; g++) if (g != ord[0]) begin ord[n] = g; n++; end
        if (code % 2 == 1) begin t = ord[1]; ord[1] = ord[2]; ord[2] = t; end
        for (int p = 0; p < 3; p++)
            for (int k = 0; k < 2; k++)
                if (act[ord[p]*2 + k]) return {1'b1, 3'(ord[p]*2 + k)};
        return 4'h0;
    endfunction

    function automatic logic [7:0] ref_read(logic [7:0] a);
        if (a == A_REQ)  return {2'b00, m_req};
        if (a == A_MASK) return {m_glob, 1'b0, m_mask};
        if (a == A_PRIO) return {5'b0, m_ord};
        return 8'h00;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_req <= '0; m_mask <= '0; m_glob <= 1'b0; m_ord <= '0;
            m_prev <= evb;
        end else begin
            e = evb & ~m_prev;
            sv = '0;
            sv[0] = rx_enable ? e[3] : e[1];
            if (uart_ctl[7])                    sv[1] = e[4];
            else if (uart_ctl[5])               sv[1] = e[5];
            else if (port_mode[1] | wake_ctl[4]) sv[1] = e[6];
            else                                sv[1] = e[2];
            sv[2] = e[0]; sv[3] = e[7]; sv[4] = e[8]; sv[5] = e[9];
            nx = (reg_wr && reg_addr == A_REQ) ? reg_wdata[5:0] : m_req;
            pk = ref_pick(m_req & m_mask & {6{m_glob}}, m_ord);
            if (irq_ack && pk[3]) nx[pk[2:0]] = 1'b0;
            nx = nx | sv;
            m_req <= nx;
            if (reg_wr && reg_addr == A_MASK) begin
                m_mask <= reg_wdata[5:0]; m_glob <= reg_wdata[7];
            end
            if (reg_wr && reg_addr == A_PRIO) m_ord <= reg_wdata[2:0];
            m_prev <= evb;
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        logic [3:0] ep;
        if (!rst && !done) begin
            ep = ref_pick(m_req & m_mask & {6{m_glob}}, m_ord);
            chk("model R8 pending", int'(irq_pending), int'(ep[3]));
            if (ep[3]) chk("model R9 vector", int'(irq_vector), int'(ep[2:0]));
            chk("model R11 rdata", int'(reg_rdata), int'(ref_read(reg_addr)));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        step(1);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [7:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic pulse(int b);
        evb[b] = 1'b1; step(1);
        evb[b] = 1'b0; step(1);
    endtask

    task automatic finish_run();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog R1 actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        logic [7:0] v;
        int cfg_sel [6];
        logic [7:0] cfg_u [6], cfg_p [6], cfg_w [6];
        int order_exp1 [8];
        int order_exp2 [6];
        logic [7:0] order_mask2 [6];

        step(3);
        rst = 1'b0;
        step(1);
        // R1
        chk("R1 pending after reset", int'(irq_pending), 0);
        rd(A_REQ, v);  chk("R1 request reg after reset", int'(v), 8'h00);
        rd(A_MASK, v); chk("R1 global enable after reset", int'(v[7]), 0);

        wr(A_MASK, 8'hBF);
        wr(A_PRIO, 8'h00);

        // R2 shared receive slot
        pulse(1); rd(A_REQ, v); chk("R2 line_b sets slot0", int'(v), 8'h01);
        wr(A_REQ, 8'h00);
        pulse(3); rd(A_REQ, v); chk("R2 rx deselected", int'(v), 8'h00);
        rx_enable = 1'b1; step(1);
        pulse(1); rd(A_REQ, v); chk("R2 line_b deselected", int'(v), 8'h00);
        pulse(3); rd(A_REQ, v); chk("R2 rx sets slot0", int'(v), 8'h01);
        wr(A_REQ, 8'h00);
        rx_enable = 1'b0; step(1);

        // R3 / R4 multi-source slot, every select combination
        cfg_u = '{8'h80, 8'hA0, 8'h20, 8'h00, 8'h00, 8'h00};
        cfg_p = '{8'h00, 8'h02, 8'h02, 8'h02, 8'h00, 8'h00};
        cfg_w = '{8'h10, 8'h00, 8'h10, 8'h00, 8'h10, 8'h00};
        cfg_sel = '{4, 4, 5, 6, 6, 2};
        for (int c = 0; c < 6; c++) begin
            uart_ctl = cfg_u[c]; port_mode = cfg_p[c]; wake_ctl = cfg_w[c];
            step(1);
            foreach (cfg_sel[i]) begin end
            for (int b = 2; b <= 6; b++) begin
                if (b != 3 && b != cfg_sel[c]) begin
                    pulse(b); rd(A_REQ, v);
                    chk(c < 3 ? "R3 deselected event on slot1" : "R4 deselected event on slot1",
                        int'(v), 8'h00);
                end
            end
            pulse(cfg_sel[c]); rd(A_REQ, v);
            chk(c < 3 ? "R3 selected event sets slot1" : "R4 selected event sets slot1",
                int'(v), 8'h02);
            wr(A_REQ, 8'h00);
        end
        uart_ctl = 8'h00; port_mode = 8'h00; wake_ctl = 8'h00;

        // R5 fixed slots
        pulse(0); rd(A_REQ, v); chk("R5 line_a slot2", int'(v), 8'h04);
        pulse(7); rd(A_REQ, v); chk("R5 timer0 slot3", int'(v), 8'h0C);
        pulse(8); rd(A_REQ, v); chk("R5 timer1 slot4", int'(v), 8'h1C);
        pulse(9); rd(A_REQ, v); chk("R5 lowvolt slot5", int'(v), 8'h3C);

        // R6 individual mask
        wr(A_REQ, 8'h3F);
        chk("R6 all enabled vector", int'(irq_vector), 0);
        wr(A_MASK, 8'hBE); chk("R6 slot0 masked", int'(irq_vector), 1);
        wr(A_MASK, 8'hB0); chk("R6 groups 0,1 masked", int'(irq_vector), 4);
        rd(A_REQ, v); chk("R6 masked requests kept", int'(v), 8'h3F);

        // R7 global disable
        wr(A_MASK, 8'h3F);
        chk("R7 no pending when global off", int'(irq_pending), 0);
        rd(A_REQ, v); chk("R7 requests kept", int'(v), 8'h3F);

        // R8 ordering codes
        order_exp1 = '{0, 0, 2, 2, 4, 4, 0, 0};
        wr(A_MASK, 8'hBF);
        for (int oc = 0; oc < 8; oc++) begin
            wr(A_PRIO, 8'(oc));
            chk("R8 first group", int'(irq_vector), order_exp1[oc]);
        end
        order_mask2 = '{8'hBC, 8'hBC, 8'hB3, 8'hB3, 8'h8F, 8'h8F};
        order_exp2  = '{2, 4, 0, 4, 0, 2};
        for (int oc = 0; oc < 6; oc++) begin
            wr(A_PRIO, 8'(oc));
            wr(A_MASK, order_mask2[oc]);
            chk("R8 second group", int'(irq_vector), order_exp2[oc]);
        end

        // R9 tie within group
        wr(A_MASK, 8'hBF); wr(A_PRIO, 8'h04);
        wr(A_REQ, 8'h30); chk("R9 lower index in group", int'(irq_vector), 4);
        wr(A_REQ, 8'h20); chk("R9 single in group", int'(irq_vector), 5);

        // R10 acknowledge
        wr(A_PRIO, 8'h00); wr(A_REQ, 8'h3F);
        irq_ack = 1'b1; step(1); irq_ack = 1'b0;
        rd(A_REQ, v); chk("R10 ack clears presented", int'(v), 8'h3E);
        chk("R10 next vector", int'(irq_vector), 1);

        // R11 register access
        wr(A_REQ, 8'h3C); rd(A_REQ, v); chk("R11 write loads request", int'(v), 8'h3C);
        rd(A_MASK, v); chk("R11 mask readback", int'(v), 8'hBF);
        wr(A_PRIO, 8'hFD); rd(A_PRIO, v); chk("R11 order readback", int'(v), 8'h05);
        rd(8'h10, v); chk("R11 other address", int'(v), 8'h00);
        wr(A_PRIO, 8'h00);

        // R12 set beats ack and write
        chk("R12 presented slot2", int'(irq_vector), 2);
        evb[0] = 1'b1; irq_ack = 1'b1; step(1);
        irq_ack = 1'b0; evb[0] = 1'b0; step(1);
        rd(A_REQ, v); chk("R12 set wins over ack", int'(v), 8'h3C);
        evb[7] = 1'b1; reg_addr = A_REQ; reg_wdata = 8'h00; reg_wr = 1'b1; step(1);
        reg_wr = 1'b0; evb[7] = 1'b0; step(1);
        rd(A_REQ, v); chk("R12 set wins over write", int'(v), 8'h08);

        // R13 level held high sets once
        wr(A_REQ, 8'h00);
        evb[9] = 1'b1; step(2);
        wr(A_REQ, 8'h00); step(3);
        rd(A_REQ, v); chk("R13 held level no re-set", int'(v), 8'h00);
        evb[9] = 1'b0; step(1);

        // random phase checked by the model every cycle
        for (int cyc = 0; cyc < 4000; cyc++) begin
            evb = 10'($urandom) & 10'($urandom);
            irq_ack = ($urandom % 4) == 0;
            reg_wr = ($urandom % 6) == 0;
            case ($urandom % 4)
                0: reg_addr = A_PRIO;
                1: reg_addr = A_REQ;
                2: reg_addr = A_MASK;
                default: reg_addr = 8'(($urandom % 16) + 8'h20);
            endcase
            reg_wdata = 8'($urandom);
            if (reg_addr == A_MASK && ($urandom % 2) == 0) reg_wdata[7] = 1'b1;
            if (cyc % 64 == 0) begin
                rx_enable = $urandom % 2;
                uart_ctl  = 8'($urandom) & 8'hA0;
                port_mode = 8'($urandom) & 8'h02;
                wake_ctl  = 8'($urandom) & 8'h10;
            end
            step(1);
        end
        reg_wr = 1'b0; irq_ack = 1'b0; evb = '0;
        step(2);
        finish_run();
    end

endmodule